// File: doc/BRIEF.md
# BCD Time and Calendar Counter

This block keeps wall-clock time and a calendar as a cascade of 4-bit BCD digits. The digits cover seconds, minutes, hours, day of week, day of month, month and a two-digit year. A one-cycle tick arrives once per second from an external prescaler. Each tick adds one second, and carries pass upward through the cascade. Hours count in a 24-hour format or in a 12-hour format with a PM flag. The number of days in each month is derived from the month digits. February gains its 29th day in the years picked by a leap-year phase field, which software writes.

The host writes a digit by raising one bit of a per-digit strobe vector while the nibble is on the data input. It reads any digit by putting the digit index on a select input. The read value is a combinational nibble. Two digit registers also hold control fields. The hour-tens nibble holds the 12/24 mode bit and the PM flag. The day-tens nibble holds the two leap-phase bits. A stop input freezes the count so the host can update several digits without a carry landing between its writes.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the digits read, by index 0..12: 0,0,0,0,0,8,0,1,0,1,0,0,0. That is 00:00:00 in 24-hour mode, day of week 0, 1st of month 01, year 00, leap phase 00.
- R2: Strobe bit k loads the data nibble into digit k. The new value reads back at select k from the next cycle. Index map: 0 sec ones, 1 sec tens, 2 min ones, 3 min tens, 4 hour ones, 5 hour tens, 6 day of week, 7 day ones, 8 day tens, 9 month ones, 10 month tens, 11 year ones, 12 year tens. Selects 13..15 read 0.
- R3: Seconds and minutes each count 00..59. Going from 59 to 00 carries one into the next field.
- R4: Hour-tens bit 3 = 1 selects 24-hour mode, where hours run 00..23 and 23→00 advances the day. In this mode hour-tens bit 2 (PM) reads 0. Bits 1:0 hold the tens digit.
- R5: Hour-tens bit 3 = 0 selects 12-hour mode, where hours run 12,01..11. On 11→12 the PM flag (bit 2, 1 = PM) toggles. The day advances only on 11 PM→12 AM.
- R6: Day of week counts 0..6 modulo 7 and advances on every day rollover.
- R7: Days count from 01. Months 04, 06, 09 and 11 end at 30, February at 28 or 29, and all other months at 31. After the last day the day becomes 01 and the month advances.
- R8: Day-tens bits 3:2 select a leap residue: 00→0, 01→3, 10→2, 11→1. A year is leap when its two-digit value modulo 4 equals that residue. These bits survive day rollover.
- R9: Months run 01..12. Month 12→01 advances the year, and year 99→00.
- R10: While stop is high, ticks have no effect on any digit.
- R11: In a cycle where any load strobe is high, a tick is discarded. Digits that are not loaded keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse, once per second |
| stop_i | input | 1 | Freeze counting |
| ld_en_i | input | 13 | Per-digit load strobes |
| ld_data_i | input | 4 | Load nibble |
| rd_sel_i | input | 4 | Read digit index |
| rd_data_o | output | 4 | Read nibble of selected digit |

## Verification
The assertions take for granted that every loaded nibble is a legal value for its digit. This covers the range checks and the single-step and wrap checks, which assume the cascade starts from a reachable state. The bench loads only in-range values. It writes the hour-tens and day-tens control fields only with valid combinations, and it sets up each rollover scenario completely before it issues a tick. The one deliberate exception is a hour-tens load that sets PM and 24-hour mode together. This tests the PM read mask, so the per-digit load-echo property excludes that digit.

// File: rtl/bcd_cal_pkg.sv
package bcd_cal_pkg;
  localparam int DIG_W   = 4;
  localparam int NUM_DIG = 13;
  localparam int SEL_W   = $clog2(NUM_DIG);
  localparam int TAB_N   = 2 ** SEL_W;

  localparam int IX_SEC1 = 0;
  localparam int IX_HR1  = 4;
  localparam int IX_HR10 = 5;
  localparam int IX_WDAY = 6;
  localparam int NUM_B60 = 2;

  // residue = (4 - sel) mod 4
  function automatic logic [1:0] leap_residue(input logic [1:0] sel);
    return 2'(~sel + 2'd1);
  endfunction
endpackage

// File: rtl/bcd_base60.sv
module bcd_base60 import bcd_cal_pkg::*; #(
  parameter int ONES_MAX = 9,
  parameter int TENS_MAX = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             ld_ones_i,
  input  logic             ld_tens_i,
  input  logic [DIG_W-1:0] ld_data_i,
  output logic [DIG_W-1:0] ones_o,
  output logic [DIG_W-1:0] tens_o,
  output logic             carry_o
);
  logic [DIG_W-1:0] ones_q, tens_q;
  logic ones_wrap, tens_wrap;

  assign ones_wrap = ones_q == DIG_W'(ONES_MAX);
  assign tens_wrap = tens_q == DIG_W'(TENS_MAX);
  assign carry_o   = inc_i & ones_wrap & tens_wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ones_q <= '0;
      tens_q <= '0;
    end else begin
      if (ld_ones_i)      ones_q <= ld_data_i;
      else if (inc_i)     ones_q <= ones_wrap ? '0 : ones_q + DIG_W'(1);
      if (ld_tens_i)      tens_q <= ld_data_i;
      else if (inc_i && ones_wrap)
                          tens_q <= tens_wrap ? '0 : tens_q + DIG_W'(1);
    end
  end

  assign ones_o = ones_q;
  assign tens_o = tens_q;
endmodule

// File: rtl/bcd_hour.sv
module bcd_hour import bcd_cal_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic             ld_ones_i,
  input  logic             ld_tens_i,
  input  logic [DIG_W-1:0] ld_data_i,
  output logic [DIG_W-1:0] ones_o,
  output logic [DIG_W-1:0] tens_o,
  output logic             carry_o
);
  logic [DIG_W-1:0] ones_q, ones_n;
  logic [1:0]       tens_q, tens_n;
  logic             mode24_q, pm_q, pm_n;
  logic             at23, at11, at12;

  assign at23 = (tens_q == 2'd2) && (ones_q == DIG_W'(3));
  assign at11 = (tens_q == 2'd1) && (ones_q == DIG_W'(1));
  assign at12 = (tens_q == 2'd1) && (ones_q == DIG_W'(2));

  always_comb begin
    ones_n = ones_q + DIG_W'(1);
    tens_n = tens_q;
    pm_n   = pm_q;
    if (mode24_q) begin
      if (at23) begin
        ones_n = '0;
        tens_n = '0;
      end else if (ones_q == DIG_W'(9)) begin
        ones_n = '0;
        tens_n = tens_q + 2'd1;
      end
    end else begin
      if (at11) begin
        pm_n = ~pm_q;
      end else if (at12) begin
        ones_n = DIG_W'(1);
        tens_n = '0;
      end else if (ones_q == DIG_W'(9)) begin
        ones_n = '0;
        tens_n = tens_q + 2'd1;
      end
    end
  end

  assign carry_o = inc_i & (mode24_q ? at23 : (at11 & pm_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ones_q   <= '0;
      tens_q   <= '0;
      mode24_q <= 1'b1;
      pm_q     <= 1'b0;
    end else begin
      if (ld_ones_i)  ones_q <= ld_data_i;
      else if (inc_i) ones_q <= ones_n;
      if (ld_tens_i) begin
        mode24_q <= ld_data_i[3];
        pm_q     <= ld_data_i[2];
        tens_q   <= ld_data_i[1:0];
      end else if (inc_i) begin
        tens_q <= tens_n;
        pm_q   <= pm_n;
      end
    end
  end

  assign ones_o = ones_q;
  assign tens_o = {mode24_q, pm_q & ~mode24_q, tens_q};
endmodule

// File: rtl/bcd_date.sv
module bcd_date import bcd_cal_pkg::*; (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             inc_i,
  input  logic [6:0]       ld_i,      // wday,d1,d10,m1,m10,y1,y10
  input  logic [DIG_W-1:0] ld_data_i,
  output logic [DIG_W-1:0] wday_o,
  output logic [DIG_W-1:0] d1_o,
  output logic [DIG_W-1:0] d10_o,
  output logic [DIG_W-1:0] m1_o,
  output logic [DIG_W-1:0] m10_o,
  output logic [DIG_W-1:0] y1_o,
  output logic [DIG_W-1:0] y10_o
);
  logic [DIG_W-1:0] wday_q, d1_q, m1_q, m10_q, y1_q, y10_q;
  logic [1:0]       d10_q, lsel_q;
  logic [4:0]       mnum;
  logic [5:0]       dnum, last_day;
  logic             leap, month_end, year_end;

  assign mnum = m10_q[0] ? 5'd10 + {1'b0, m1_q} : {1'b0, m1_q};
  assign dnum = 6'({d10_q, 3'b000}) + 6'({d10_q, 1'b0}) + 6'(d1_q);
  assign leap = 2'({y10_q[0], 1'b0} + y1_q[1:0]) == leap_residue(lsel_q);

  always_comb begin
    case (mnum)
      5'd2:                       last_day = leap ? 6'd29 : 6'd28;
      5'd4, 5'd6, 5'd9, 5'd11:    last_day = 6'd30;
      default:                    last_day = 6'd31;
    endcase
  end

  assign month_end = dnum == last_day;
  assign year_end  = mnum == 5'd12;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wday_q <= '0;
      d1_q   <= DIG_W'(1);
      d10_q  <= '0;
      lsel_q <= '0;
      m1_q   <= DIG_W'(1);
      m10_q  <= '0;
      y1_q   <= '0;
      y10_q  <= '0;
    end else begin
      if (ld_i[0])     wday_q <= ld_data_i;
      else if (inc_i)  wday_q <= (wday_q == DIG_W'(6)) ? '0 : wday_q + DIG_W'(1);

      if (ld_i[1])     d1_q <= ld_data_i;
      else if (inc_i)  d1_q <= month_end ? DIG_W'(1) :
                               (d1_q == DIG_W'(9)) ? '0 : d1_q + DIG_W'(1);

      if (ld_i[2]) begin
        lsel_q <= ld_data_i[3:2];
        d10_q  <= ld_data_i[1:0];
      end else if (inc_i) begin
        if (month_end)                d10_q <= '0;
        else if (d1_q == DIG_W'(9))   d10_q <= d10_q + 2'd1;
      end

      if (ld_i[3])     m1_q <= ld_data_i;
      else if (inc_i && month_end)
                       m1_q <= year_end ? DIG_W'(1) :
                               (m1_q == DIG_W'(9)) ? '0 : m1_q + DIG_W'(1);

      if (ld_i[4])     m10_q <= ld_data_i;
      else if (inc_i && month_end) begin
        if (year_end)                 m10_q <= '0;
        else if (m1_q == DIG_W'(9))   m10_q <= DIG_W'(1);
      end

      if (ld_i[5])     y1_q <= ld_data_i;
      else if (inc_i && month_end && year_end)
                       y1_q <= (y1_q == DIG_W'(9)) ? '0 : y1_q + DIG_W'(1);

      if (ld_i[6])     y10_q <= ld_data_i;
      else if (inc_i && month_end && year_end && y1_q == DIG_W'(9))
                       y10_q <= (y10_q == DIG_W'(9)) ? '0 : y10_q + DIG_W'(1);
    end
  end

  assign wday_o = wday_q;
  assign d1_o   = d1_q;
  assign d10_o  = {lsel_q, d10_q};
  assign m1_o   = m1_q;
  assign m10_o  = m10_q;
  assign y1_o   = y1_q;
  assign y10_o  = y10_q;
endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar import bcd_cal_pkg::*; (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               stop_i,
  input  logic [NUM_DIG-1:0] ld_en_i,
  input  logic [DIG_W-1:0]   ld_data_i,
  input  logic [SEL_W-1:0]   rd_sel_i,
  output logic [DIG_W-1:0]   rd_data_o
);
  logic                            adv;
  logic [NUM_B60:0]                cas;  // cas[0] = second tick, cas[k+1] = carry out of stage k
  logic [NUM_B60-1:0][DIG_W-1:0]   b60_ones, b60_tens;
  logic                            day_inc;
  logic [NUM_DIG-1:0][DIG_W-1:0]   dig;
  logic [TAB_N-1:0][DIG_W-1:0]     rd_tab;

  // any load in this cycle discards the tick
  assign adv    = tick_i & ~stop_i & ~|ld_en_i;
  assign cas[0] = adv;

  for (genvar g = 0; g < NUM_B60; g++) begin : g_b60
    bcd_base60 #(.ONES_MAX(9), .TENS_MAX(5)) u_b60 (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .inc_i     (cas[g]),
      .ld_ones_i (ld_en_i[2*g]),
      .ld_tens_i (ld_en_i[2*g+1]),
      .ld_data_i (ld_data_i),
      .ones_o    (b60_ones[g]),
      .tens_o    (b60_tens[g]),
      .carry_o   (cas[g+1])
    );
    assign dig[2*g]   = b60_ones[g];
    assign dig[2*g+1] = b60_tens[g];
  end

  bcd_hour u_hour (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_i     (cas[NUM_B60]),
    .ld_ones_i (ld_en_i[IX_HR1]),
    .ld_tens_i (ld_en_i[IX_HR10]),
    .ld_data_i (ld_data_i),
    .ones_o    (dig[IX_HR1]),
    .tens_o    (dig[IX_HR10]),
    .carry_o   (day_inc)
  );

  bcd_date u_date (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_i     (day_inc),
    .ld_i      (ld_en_i[NUM_DIG-1:IX_WDAY]),
    .ld_data_i (ld_data_i),
    .wday_o    (dig[6]),
    .d1_o      (dig[7]),
    .d10_o     (dig[8]),
    .m1_o      (dig[9]),
    .m10_o     (dig[10]),
    .y1_o      (dig[11]),
    .y10_o     (dig[12])
  );

  always_comb begin
    rd_tab              = '0;
    rd_tab[NUM_DIG-1:0] = dig;
  end
  assign rd_data_o = rd_tab[rd_sel_i];
endmodule

// File: rtl/bcd_calendar_chk.sv
module bcd_calendar_chk import bcd_cal_pkg::*; (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          tick_i,
  input logic                          stop_i,
  input logic [NUM_DIG-1:0]            ld_en_i,
  input logic [DIG_W-1:0]              ld_data_i,
  input logic [SEL_W-1:0]              rd_sel_i,
  input logic [DIG_W-1:0]              rd_data_o,
  input logic [NUM_DIG-1:0][DIG_W-1:0] dig
);
  logic step;
  assign step = tick_i && !stop_i && (ld_en_i == '0);

  AST_STOP_FREEZE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_i && ld_en_i == '0) |=> $stable(dig)); // R10

  AST_TICK_DISCARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && ld_en_i != '0 && !ld_en_i[IX_SEC1]) |=> $stable(dig[IX_SEC1])); // R11

  AST_SEC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && dig[1] == 4'd5 && dig[0] == 4'd9) |=> (dig[0] == 4'd0 && dig[1] == 4'd0)); // R3

  AST_SEC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && dig[0] < 4'd9) |=> dig[0] == $past(dig[0]) + 4'd1); // R3

  AST_PM_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_sel_i == SEL_W'(IX_HR10) && rd_data_o[3]) |-> !rd_data_o[2]); // R4

  AST_DAY_24: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step && dig[5] == 4'b1010 && dig[4] == 4'd3 && dig[3] == 4'd5 &&
     dig[2] == 4'd9 && dig[1] == 4'd5 && dig[0] == 4'd9)
    |=> (dig[5] == 4'b1000 && dig[4] == 4'd0)); // R4

  AST_WDAY_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dig[IX_WDAY] <= 4'd6); // R6

  for (genvar k = 0; k < NUM_DIG; k++) begin : g_ld
    if (k != IX_HR10) begin : g_chk
      AST_LOAD_ECHO: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ld_en_i[k] |=> dig[k] == $past(ld_data_i)); // R2
    end
  end
endmodule

bind bcd_calendar bcd_calendar_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .tick_i    (tick_i),
  .stop_i    (stop_i),
  .ld_en_i   (ld_en_i),
  .ld_data_i (ld_data_i),
  .rd_sel_i  (rd_sel_i),
  .rd_data_o (rd_data_o),
  .dig       (dig)
);

// File: tb/bcd_calendar_test.sv
module bcd_calendar_test;
  import bcd_cal_pkg::*;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               tick_i = 1'b0;
  logic               stop_i = 1'b0;
  logic [NUM_DIG-1:0] ld_en_i = '0;
  logic [DIG_W-1:0]   ld_data_i = '0;
  logic [SEL_W-1:0]   rd_sel_i = '0;
  logic [DIG_W-1:0]   rd_data_o;

  int errs = 0, nchk = 0;
  bit done = 0;

  typedef struct {
    logic [SEL_W-1:0] sel;
    logic [DIG_W-1:0] val;
    string            tag;
  } item_t;
  item_t sb_q[$];
  bit mon_busy = 0;

  bcd_calendar uut (.*);

  always #5 clk_i = ~clk_i;

  // monitor: pops expected items, reads the digit back and compares
  initial forever begin
    item_t it;
    wait (sb_q.size() > 0);
    mon_busy = 1;
    it = sb_q.pop_front();
    rd_sel_i = it.sel;
    #0.5;
    nchk++;
    if (rd_data_o !== it.val) begin
      errs++;
      $display("FAIL %s digit %0d actual=%0h expected=%0h", it.tag, it.sel, rd_data_o, it.val);
    end
    mon_busy = 0;
  end

  task automatic expect_dig(input int sel, input logic [3:0] val, input string tag);
    item_t it;
    it.sel = SEL_W'(sel);
    it.val = val;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  task automatic drain();
    wait (sb_q.size() == 0 && !mon_busy);
    #0.1;
    wait (sb_q.size() == 0 && !mon_busy);
  endtask

  task automatic load(input int idx, input logic [3:0] val);
    @(negedge clk_i);
    ld_en_i = NUM_DIG'(1) << idx;
    ld_data_i = val;
    @(negedge clk_i);
    ld_en_i = '0;
  endtask

  task automatic load_with_tick(input int idx, input logic [3:0] val);
    @(negedge clk_i);
    ld_en_i = NUM_DIG'(1) << idx;
    ld_data_i = val;
    tick_i = 1'b1;
    @(negedge clk_i);
    ld_en_i = '0;
    tick_i = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      tick_i = 1'b1;
      @(negedge clk_i);
      tick_i = 1'b0;
    end
  endtask

  task automatic set_mmss_5959();
    load(0, 4'd9); load(1, 4'd5); load(2, 4'd9); load(3, 4'd5);
  endtask

  // 23:59:59 in 24-hour mode, then one tick
  task automatic day_edge();
    set_mmss_5959();
    load(4, 4'd3); load(5, 4'b1010);
    tick(1);
  endtask

  task automatic set_date(input logic [3:0] d10, d1, m10, m1, y10, y1);
    load(8, d10); load(7, d1); load(10, m10); load(9, m1); load(12, y10); load(11, y1);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errs++; nchk++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, nchk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset values
    expect_dig(0, 4'd0, "R1"); expect_dig(1, 4'd0, "R1"); expect_dig(2, 4'd0, "R1");
    expect_dig(3, 4'd0, "R1"); expect_dig(4, 4'd0, "R1"); expect_dig(5, 4'd8, "R1");
    expect_dig(6, 4'd0, "R1"); expect_dig(7, 4'd1, "R1"); expect_dig(8, 4'd0, "R1");
    expect_dig(9, 4'd1, "R1"); expect_dig(10, 4'd0, "R1"); expect_dig(11, 4'd0, "R1");
    expect_dig(12, 4'd0, "R1");
    expect_dig(13, 4'd0, "R2"); expect_dig(15, 4'd0, "R2");
    drain();

    // R2 load and read back; R3 second/minute carry; R4 hour step
    load(0, 4'd7); load(1, 4'd5); load(2, 4'd9); load(3, 4'd5);
    load(4, 4'd4); load(5, 4'b1001);
    expect_dig(0, 4'd7, "R2"); expect_dig(1, 4'd5, "R2"); expect_dig(4, 4'd4, "R2");
    drain();
    tick(3);
    expect_dig(0, 4'd0, "R3"); expect_dig(1, 4'd0, "R3");
    expect_dig(2, 4'd0, "R3"); expect_dig(3, 4'd0, "R3");
    expect_dig(4, 4'd5, "R4"); expect_dig(5, 4'b1001, "R4");
    drain();
    tick(1);
    expect_dig(0, 4'd1, "R3");
    drain();

    // R10 stop
    stop_i = 1'b1;
    tick(4);
    expect_dig(0, 4'd1, "R10"); expect_dig(2, 4'd0, "R10");
    drain();
    stop_i = 1'b0;

    // R11 load wins over tick
    load_with_tick(2, 4'd3);
    expect_dig(2, 4'd3, "R11"); expect_dig(0, 4'd1, "R11");
    drain();

    // R4 PM flag masked in 24-hour mode
    load(5, 4'b1100);
    expect_dig(5, 4'd8, "R4");
    drain();

    // R4 23:59:59 -> 00:00:00, R6 wday 6 -> 0, R7 day 15 -> 16
    load(6, 4'd6);
    set_date(4'd1, 4'd5, 4'd0, 4'd3, 4'd2, 4'd4);
    day_edge();
    expect_dig(0, 4'd0, "R4"); expect_dig(2, 4'd0, "R4"); expect_dig(3, 4'd0, "R4");
    expect_dig(4, 4'd0, "R4"); expect_dig(5, 4'd8, "R4");
    expect_dig(6, 4'd0, "R6"); expect_dig(7, 4'd6, "R7"); expect_dig(8, 4'd1, "R7");
    drain();

    // R5 12-hour: 11 AM -> 12 PM, no day advance
    load(5, 4'b0001); load(4, 4'd1);
    set_mmss_5959();
    tick(1);
    expect_dig(4, 4'd2, "R5"); expect_dig(5, 4'b0101, "R5"); expect_dig(7, 4'd6, "R5");
    drain();
    // 12 PM -> 1 PM
    set_mmss_5959();
    tick(1);
    expect_dig(4, 4'd1, "R5"); expect_dig(5, 4'b0100, "R5");
    drain();
    // 11 PM -> 12 AM, day and weekday advance
    load(5, 4'b0101); load(4, 4'd1);
    set_mmss_5959();
    tick(1);
    expect_dig(4, 4'd2, "R5"); expect_dig(5, 4'b0001, "R5");
    expect_dig(7, 4'd7, "R5"); expect_dig(6, 4'd1, "R6");
    drain();

    // R7 Apr 30 -> May 01
    set_date(4'd3, 4'd0, 4'd0, 4'd4, 4'd2, 4'd4);
    day_edge();
    expect_dig(7, 4'd1, "R7"); expect_dig(8, 4'd0, "R7"); expect_dig(9, 4'd5, "R7");
    drain();

    // R7 Jan 30 -> 31 -> Feb 01
    set_date(4'd3, 4'd0, 4'd0, 4'd1, 4'd2, 4'd4);
    day_edge();
    expect_dig(7, 4'd1, "R7"); expect_dig(8, 4'd3, "R7"); expect_dig(9, 4'd1, "R7");
    drain();
    day_edge();
    expect_dig(7, 4'd1, "R7"); expect_dig(8, 4'd0, "R7"); expect_dig(9, 4'd2, "R7");
    drain();

    // R8 Feb 28 year 23, phase 00: not leap
    set_date(4'd2, 4'd8, 4'd0, 4'd2, 4'd2, 4'd3);
    day_edge();
    expect_dig(7, 4'd1, "R8"); expect_dig(9, 4'd3, "R8");
    drain();

    // R8 Feb 28 year 96, phase 00: leap
    set_date(4'd2, 4'd8, 4'd0, 4'd2, 4'd9, 4'd6);
    day_edge();
    expect_dig(7, 4'd9, "R8"); expect_dig(8, 4'd2, "R8"); expect_dig(9, 4'd2, "R8");
    drain();
    day_edge();
    expect_dig(7, 4'd1, "R8"); expect_dig(9, 4'd3, "R8");
    drain();

    // R8 phase 01 (residue 3): year 23 leap, year 24 not
    set_date(4'b0110, 4'd8, 4'd0, 4'd2, 4'd2, 4'd3);
    day_edge();
    expect_dig(7, 4'd9, "R8"); expect_dig(8, 4'b0110, "R8");
    drain();
    set_date(4'b0110, 4'd8, 4'd0, 4'd2, 4'd2, 4'd4);
    day_edge();
    expect_dig(7, 4'd1, "R8"); expect_dig(8, 4'b0100, "R8"); expect_dig(9, 4'd3, "R8");
    drain();

    // R7/R9 Sep 30 -> Oct 01
    set_date(4'd3, 4'd0, 4'd0, 4'd9, 4'd2, 4'd4);
    day_edge();
    expect_dig(7, 4'd1, "R7"); expect_dig(9, 4'd0, "R9"); expect_dig(10, 4'd1, "R9");
    drain();

    // R9 Dec 31 year 99 -> Jan 01 year 00
    set_date(4'd3, 4'd1, 4'd1, 4'd2, 4'd9, 4'd9);
    day_edge();
    expect_dig(7, 4'd1, "R9"); expect_dig(8, 4'd0, "R9"); expect_dig(9, 4'd1, "R9");
    expect_dig(10, 4'd0, "R9"); expect_dig(11, 4'd0, "R9"); expect_dig(12, 4'd0, "R9");
    drain();

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, nchk);
    $finish;
  end
endmodule